// File: doc/BRIEF.md
# Next Program Counter Unit

This block holds the program counter of a 32-bit processor whose instructions are all 32 bits wide. On every clock edge it works out the address of the next instruction and loads it. The inputs are the fetched instruction word, the two register operands that a conditional branch compares, and a register value that a register-indirect jump uses. The next address can be one of five: the sequential address, a PC-relative branch target, an absolute jump target inside the current 256 MiB region, a jump-and-link target, or a full 32-bit register target.

Branch offsets count words and are measured from the instruction after the branch. Jump fields are word indices. For a jump-and-link, the block also registers the return address and raises a one-cycle strobe, so that the register file can write the link. That write is not part of this block.

All outputs are registered. A synchronous, active-high reset loads a word-aligned reset vector.

Top module: `npc_unit`

## Requirements
- R1: While `rst` is high at a clock edge, `pc` loads `RESET_VEC` (default 0x0000_1000, low two bits zero) and `link_valid` goes low.
- R2: The opcode is `instr[31:26]`. Any opcode other than 0, 2, 3, 4 or 5 loads `pc+4`. Opcode 0 with a function code `instr[5:0]` other than 8 also loads `pc+4`.
- R3: Sequential addition wraps modulo 2^32, so 0xFFFF_FFFC is followed by 0x0000_0000.
- R4: Opcode 4 (branch if equal) with `op_a == op_b` loads `pc + 4 + sext(instr[15:0]) * 4`. The register fields `instr[25:16]` have no effect, because the operands come from the ports.
- R5: Opcode 5 (branch if not equal) with `op_a != op_b` loads the same PC-relative target as R4.
- R6: A branch whose condition fails loads `pc+4`.
- R7: Opcode 2 (jump) loads `{(pc+4)[31:28], instr[25:0], 2'b00}`.
- R8: Opcode 3 (jump and link) loads the R7 target. In the following cycle it also shows `link_valid = 1` and `link_addr = pc+4`.
- R9: Opcode 0 with function code 8 (jump to register) loads `jr_target` unchanged, all 32 bits, even when it is not word aligned.
- R10: After any instruction other than opcode 3, `link_valid` is 0.
- R11: The branch reach covers the full signed offset range, from -32768 words (0x8000) to +32767 words (0x7FFF).
- R12: The upper four bits of a jump target come from `pc+4`, not from `pc`. A jump placed at 0x0FFF_FFFC therefore lands in region 0x1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr | input | 32 | Instruction fetched at the current `pc` |
| op_a | input | 32 | First operand for the branch compare |
| op_b | input | 32 | Second operand for the branch compare |
| jr_target | input | 32 | Register value used by jump to register |
| pc | output | 32 | Current program counter (registered) |
| link_addr | output | 32 | Return address of the last jump and link |
| link_valid | output | 1 | One-cycle strobe: `link_addr` is valid |

## Verification
A jump and link changes the program counter and produces the link strobe on the same edge. The bench sweeps many jump indices and checks, after each edge, the new `pc` together with `link_valid` and `link_addr` against the old `pc+4`. Region selection and sequential increment also meet in one cycle. The bench places a jump at 0x0FFF_FFFC and a plain instruction at 0xFFFF_FFFC, then judges the result against the arithmetic model. The model takes the upper bits from the incremented address.

// File: rtl/npc_pkg.sv
`timescale 1ns/1ps
package npc_pkg;
  localparam int OP_W = 6;
  localparam int FN_W = 6;

  localparam logic [OP_W-1:0] OP_SPECIAL = 6'd0;
  localparam logic [OP_W-1:0] OP_JMP     = 6'd2;
  localparam logic [OP_W-1:0] OP_JLINK   = 6'd3;
  localparam logic [OP_W-1:0] OP_BREQ    = 6'd4;
  localparam logic [OP_W-1:0] OP_BRNE    = 6'd5;
  localparam logic [FN_W-1:0] FN_JREG    = 6'd8;

  typedef struct packed {
    logic br_eq;
    logic br_ne;
    logic jmp;
    logic jlink;
    logic jreg;
  } flow_kind_t;

  typedef enum logic [2:0] {
    SEL_SEQ,
    SEL_BRANCH,
    SEL_JUMP,
    SEL_REG
  } npc_sel_e;
endpackage

// File: rtl/npc_decode.sv
`timescale 1ns/1ps
module npc_decode
  import npc_pkg::*;
(
  input  logic [OP_W-1:0] opcode,
  input  logic [FN_W-1:0] funct,
  output flow_kind_t      kind
);
  always_comb begin
    kind       = '0;
    kind.br_eq = (opcode == OP_BREQ);
    kind.br_ne = (opcode == OP_BRNE);
    kind.jmp   = (opcode == OP_JMP);
    kind.jlink = (opcode == OP_JLINK);
    kind.jreg  = (opcode == OP_SPECIAL) && (funct == FN_JREG);
  end
endmodule

// File: rtl/npc_targets.sv
`timescale 1ns/1ps
module npc_targets #(
  parameter int XLEN  = 32,
  parameter int IMM_W = 16,
  parameter int TGT_W = 26
) (
  input  logic [XLEN-1:0]  cur_pc,
  input  logic [TGT_W-1:0] low_field,
  output logic [XLEN-1:0]  seq_addr,
  output logic [XLEN-1:0]  branch_addr,
  output logic [XLEN-1:0]  jump_addr
);
  localparam int SEXT_W   = XLEN - IMM_W - 2;
  localparam int REGION_W = XLEN - TGT_W - 2;

  logic [IMM_W-1:0] word_off;
  logic [XLEN-1:0]  byte_disp;

  assign word_off    = low_field[IMM_W-1:0];
  assign byte_disp   = {{SEXT_W{word_off[IMM_W-1]}}, word_off, 2'b00};
  assign seq_addr    = cur_pc + XLEN'(4);
  assign branch_addr = seq_addr + byte_disp;
  assign jump_addr   = {seq_addr[XLEN-1 -: REGION_W], low_field, 2'b00};
endmodule

// File: rtl/npc_select.sv
`timescale 1ns/1ps
module npc_select
  import npc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  flow_kind_t      kind,
  input  logic [XLEN-1:0] op_a,
  input  logic [XLEN-1:0] op_b,
  input  logic [XLEN-1:0] seq_addr,
  input  logic [XLEN-1:0] branch_addr,
  input  logic [XLEN-1:0] jump_addr,
  input  logic [XLEN-1:0] reg_addr,
  output logic [XLEN-1:0] next_addr
);
  logic     same;
  npc_sel_e sel;

  assign same = (op_a == op_b);

  always_comb begin
    sel = SEL_SEQ;
    if (kind.jreg)                       sel = SEL_REG;
    else if (kind.jmp || kind.jlink)     sel = SEL_JUMP;
    else if ((kind.br_eq && same) ||
             (kind.br_ne && !same))      sel = SEL_BRANCH;
  end

  always_comb begin
    unique case (sel)
      SEL_BRANCH: next_addr = branch_addr;
      SEL_JUMP:   next_addr = jump_addr;
      SEL_REG:    next_addr = reg_addr;
      default:    next_addr = seq_addr;
    endcase
  end
endmodule

// File: rtl/npc_unit.sv
`timescale 1ns/1ps
module npc_unit
  import npc_pkg::*;
#(
  parameter int             XLEN      = 32,
  parameter int             IMM_W     = 16,
  parameter int             TGT_W     = 26,
  parameter logic [31:0]    RESET_VEC = 32'h0000_1000
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [XLEN-1:0] instr,
  input  logic [XLEN-1:0] op_a,
  input  logic [XLEN-1:0] op_b,
  input  logic [XLEN-1:0] jr_target,
  output logic [XLEN-1:0] pc,
  output logic [XLEN-1:0] link_addr,
  output logic            link_valid
);
  localparam logic [XLEN-1:0] BOOT = XLEN'(RESET_VEC);

  flow_kind_t      kind;
  logic [XLEN-1:0] seq_addr, branch_addr, jump_addr, next_addr;
  logic [XLEN-1:0] pc_q, link_addr_q;
  logic            link_valid_q;
  logic            rst_d = 1'b0;

  npc_decode u_decode (
    .opcode (instr[XLEN-1 -: OP_W]),
    .funct  (instr[FN_W-1:0]),
    .kind   (kind)
  );

  npc_targets #(.XLEN(XLEN), .IMM_W(IMM_W), .TGT_W(TGT_W)) u_targets (
    .cur_pc      (pc_q),
    .low_field   (instr[TGT_W-1:0]),
    .seq_addr    (seq_addr),
    .branch_addr (branch_addr),
    .jump_addr   (jump_addr)
  );

  npc_select #(.XLEN(XLEN)) u_select (
    .kind        (kind),
    .op_a        (op_a),
    .op_b        (op_b),
    .seq_addr    (seq_addr),
    .branch_addr (branch_addr),
    .jump_addr   (jump_addr),
    .reg_addr    (jr_target),
    .next_addr   (next_addr)
  );

  always_ff @(posedge clk) begin
    rst_d <= rst;
    if (rst) begin
      pc_q         <= BOOT;
      link_addr_q  <= '0;
      link_valid_q <= 1'b0;
    end else begin
      pc_q         <= next_addr;
      link_valid_q <= kind.jlink;
      if (kind.jlink) link_addr_q <= seq_addr;
    end
  end

  assign pc         = pc_q;
  assign link_addr  = link_addr_q;
  assign link_valid = link_valid_q;

  // R1: the edge after a reset edge still sees the vector
  always @(posedge clk) begin
    if (rst_d) begin
      a_r1_reset_vec: assert (pc_q == BOOT && !link_valid_q);
    end
  end

  a_r2_sequential: assert property (@(posedge clk) disable iff (rst)
    (kind == '0) |=> (pc_q == $past(pc_q) + XLEN'(4)));

  a_r6_untaken: assert property (@(posedge clk) disable iff (rst)
    ((kind.br_eq && op_a != op_b) || (kind.br_ne && op_a == op_b))
      |=> (pc_q == $past(pc_q) + XLEN'(4)));

  a_r8_link: assert property (@(posedge clk) disable iff (rst)
    kind.jlink |=> (link_valid_q && link_addr_q == $past(pc_q) + XLEN'(4)));

  a_r10_no_link: assert property (@(posedge clk) disable iff (rst)
    !kind.jlink |=> !link_valid_q);

  a_r9_reg_jump: assert property (@(posedge clk) disable iff (rst)
    kind.jreg |=> (pc_q == $past(jr_target)));
endmodule

// File: tb/npc_unit_bench.sv
`timescale 1ns/1ps
module npc_unit_bench;
  localparam logic [31:0] RV = 32'h0000_1000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] instr = '0, op_a = '0, op_b = '0, jr_target = '0;
  logic [31:0] pc, link_addr;
  logic        link_valid;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [31:0] exp_pc;

  always #4 clk = ~clk;

  npc_unit #(.RESET_VEC(RV)) u_npc_unit (
    .clk(clk), .rst(rst), .instr(instr), .op_a(op_a), .op_b(op_b),
    .jr_target(jr_target), .pc(pc), .link_addr(link_addr),
    .link_valid(link_valid)
  );

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  function automatic logic [31:0] model(input logic [31:0] p, input logic [31:0] ins,
                                        input logic [31:0] a, input logic [31:0] b,
                                        input logic [31:0] j);
    logic [31:0] s, br, jt;
    s  = p + 32'd4;
    br = s + {{14{ins[15]}}, ins[15:0], 2'b00};
    jt = {s[31:28], ins[25:0], 2'b00};
    case (ins[31:26])
      6'd0:    return (ins[5:0] == 6'd8) ? j : s;
      6'd2,
      6'd3:    return jt;
      6'd4:    return (a == b) ? br : s;
      6'd5:    return (a != b) ? br : s;
      default: return s;
    endcase
  endfunction

  // drive at posedge+2, check at the next posedge+2
  task automatic step(input logic [31:0] ins, input logic [31:0] a,
                      input logic [31:0] b, input logic [31:0] j, input string req);
    logic [31:0] e, old;
    old = exp_pc;
    e = model(old, ins, a, b, j);
    instr = ins; op_a = a; op_b = b; jr_target = j;
    @(posedge clk); #2;
    check(pc === e, req, pc, e);
    if (ins[31:26] == 6'd3) begin
      check(link_valid === 1'b1, "R8 strobe", {31'd0, link_valid}, 32'd1);
      check(link_addr === old + 32'd4, "R8 addr", link_addr, old + 32'd4);
    end else begin
      check(link_valid === 1'b0, "R10", {31'd0, link_valid}, 32'd0);
    end
    exp_pc = e;
  endtask

  task automatic go_to(input logic [31:0] target);
    step({6'd0, 20'hABCDE, 6'd8}, 32'd1, 32'd2, target, "R9");
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(posedge clk); #2;
    @(posedge clk); #2;
    check(pc === RV, "R1 pc", pc, RV);
    check(link_valid === 1'b0, "R1 link", {31'd0, link_valid}, 32'd0);
    rst = 1'b0;
    exp_pc = RV;
  endtask

  initial begin
    #(8ns * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog R1: actual timeout expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    do_reset();

    // R2 opcode sweep from a known place
    go_to(32'h0040_0000);
    for (int op = 0; op < 64; op++) begin
      logic [31:0] ins;
      ins = {op[5:0], 26'h2AB_CDEF ^ 26'(op * 1103)};
      if (ins[31:26] == 6'd0 && ins[5:0] == 6'd8) ins[0] = 1'b1;
      step(ins, 32'h55, (op % 2 == 0) ? 32'h55 : 32'h56, 32'h0, "R2");
    end

    // R4 R5 R6 R11 branch offsets, including both extremes
    go_to(32'h8000_0000);
    for (int i = 0; i < 44; i++) begin
      logic [15:0] off;
      if (i == 40)      off = 16'h8000;
      else if (i == 41) off = 16'h7FFF;
      else if (i == 42) off = 16'h0000;
      else if (i == 43) off = 16'hFFFF;
      else              off = 16'(i * 1667 - 32768);
      step({6'd4, 5'(i), 5'(31 - i), off}, 32'(i), 32'(i), 0, "R4 R11");
      step({6'd4, 5'(i), 5'(i), off}, 32'(i), 32'(i + 1), 0, "R6 eq");
      step({6'd5, 5'(i), 5'(i), off}, 32'hF0, 32'(i), 0, "R5 R11");
      step({6'd5, 10'h3FF, off}, 32'(i * 7), 32'(i * 7), 0, "R6 ne");
    end

    // R7 R8 jumps and links across patterns
    for (int i = 0; i < 32; i++) begin
      logic [25:0] idx;
      idx = 26'(i * 2097151 + 12345);
      step({6'd2, idx}, 0, 0, 0, "R7");
      step({6'd3, ~idx}, 0, 0, 0, "R8");
    end

    // R12 region from pc+4
    go_to(32'h0FFF_FFFC);
    step({6'd2, 26'h000_0010}, 0, 0, 0, "R12");
    go_to(32'h0FFF_FFFC);
    step({6'd3, 26'h3FF_FFFF}, 0, 0, 0, "R12 link");

    // R3 wrap
    go_to(32'hFFFF_FFFC);
    step({6'd8, 26'h0}, 0, 0, 0, "R3");

    // R9 funct sweep, misaligned register target
    for (int f = 0; f < 64; f++) begin
      step({6'd0, 20'h12345, f[5:0]}, 0, 0, 32'h1234_5677 + 32'(f), (f == 8) ? "R9" : "R2");
    end
    go_to(32'h0000_2000);

    // R1 mid-run reset right after a link
    step({6'd3, 26'h00_1234}, 0, 0, 0, "R8");
    do_reset();
    step(32'h2000_0000, 0, 0, 0, "R1 resume");

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule